// File: doc/BRIEF.md
# Color Subcarrier Phase NCO

This block is the numerically controlled oscillator that sets the color subcarrier phase for a composite video encoder. It runs on the pixel clock. Every cycle it adds a frequency control word to a phase accumulator. It then presents the top eight bits of that accumulator, shifted by a programmable phase offset, as the subcarrier phase for the downstream chroma modulator.

Software selects a broadcast standard through a small write-only register port, and each standard has a built-in frequency word. A programmed 32-bit word, written as two 16-bit halves, can replace the built-in word when custom frequency is enabled. In SECAM mode the programmed word always drives the Dr accumulator. A second, independently programmed word drives a Db accumulator, and a line-alternation input chooses which of the two phases reaches the output.

Top module: `subcarrier_nco`

## Requirements
- R1: After reset, the output phase is 0, both accumulators hold 0, the standard code is 0 with SECAM and custom frequency off, the phase offset is 0, the programmed word is 0, and the Db word is 0x284BDA13.
- R2: On every clock edge without soft reset, each accumulator adds the low 31 bits of its word modulo 2^31, so a word of 0x80000000 equals the pixel rate and leaves the phase fixed. The output phase is accumulator bits [30:23] plus the offset, modulo 256, and it follows the accumulator with no added register.
- R3: With SECAM and custom frequency off, the standard code in control bits [1:0] picks the built-in word: 0 gives 0x21F07C1F, 1 gives 0x2A098ACB, 2 gives 0x21E6EFE3, and 3 gives 0x21F69446.
- R4: Control bit 3 (custom enable) makes the main accumulator use the programmed word instead of the built-in word. Clearing it restores the built-in word.
- R5: A write to address 1 stages the upper 16 bits of the programmed word and changes nothing by itself. A write to address 2 loads the full word, made of the staged upper half and the written lower half, at that clock edge.
- R6: With control bit 2 (SECAM) set, the main accumulator uses the programmed word whatever the custom bit says. The Db accumulator uses the Db word, staged at address 4 and loaded at address 5 in the same way as R5. When lineAlt is 1 the output shows the Db phase, and when lineAlt is 0 it shows the Dr phase.
- R7: Address 3 bits [7:0] set the phase offset, in steps of 360/256 degrees, and it is added to the selected phase.
- R8: The softReset input clears both accumulators at the next edge and keeps every register value.
- R9: Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| softReset | input | 1 | Synchronous clear of both accumulators |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address (0 control, 1/2 word high/low, 3 offset, 4/5 Db high/low) |
| wrData | input | 16 | Register write data |
| lineAlt | input | 1 | In SECAM mode, selects the Db phase when 1 |
| phaseOut | output | 8 | Subcarrier phase, 256 steps per cycle |

## Verification
The bench runs each built-in word for 16384 pixel cycles and compares the phase every cycle against a 64-bit arithmetic model. This separates a wrong table entry from a wrong wrap width or wrong bit slice. Custom runs check that a lone upper-half write leaves the word unchanged and that the lower-half write commits both halves together, and a word of 0x80000000 holds the phase still. SECAM runs keep lineAlt fixed at each level and then toggle it. This shows that the two accumulators advance independently and that the custom bit has no effect on the Dr word. Soft reset in the middle of a run and writes to the unused addresses complete the set.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int FCW_W  = 32;
  localparam int ACC_W  = 31;
  localparam int PH_W   = 8;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_FHI   = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLO   = 3'd2;
  localparam logic [ADDR_W-1:0] A_PHOFF = 3'd3;
  localparam logic [ADDR_W-1:0] A_DBHI  = 3'd4;
  localparam logic [ADDR_W-1:0] A_DBLO  = 3'd5;

  localparam logic [FCW_W-1:0] DB_RESET = 32'h284BDA13;

  typedef enum logic [1:0] {
    STD_NTSC = 2'd0,
    STD_PAL  = 2'd1,
    STD_PALM = 2'd2,
    STD_PALN = 2'd3
  } std_e;

  typedef struct packed {
    logic             clearAcc;
    logic [FCW_W-1:0] wordMain;
    logic [FCW_W-1:0] wordAlt;
    logic             pickAlt;
    logic [PH_W-1:0]  offset;
  } nco_strobe_t;

  function automatic logic [FCW_W-1:0] builtinWord(std_e s);
    case (s)
      STD_NTSC: return 32'h21F07C1F;
      STD_PAL:  return 32'h2A098ACB;
      STD_PALM: return 32'h21E6EFE3;
      default:  return 32'h21F69446;
    endcase
  endfunction
endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              softReset,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              lineAlt,
  output nco_strobe_t       strb
);
  std_e             stdSel;
  logic             secamEn;
  logic             customEn;
  logic [REG_W-1:0] hiStage;
  logic [REG_W-1:0] dbHiStage;
  logic [FCW_W-1:0] progWord;
  logic [FCW_W-1:0] dbWord;
  logic [PH_W-1:0]  phaseOff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stdSel    <= STD_NTSC;
      secamEn   <= 1'b0;
      customEn  <= 1'b0;
      hiStage   <= '0;
      dbHiStage <= DB_RESET[FCW_W-1 -: REG_W];
      progWord  <= '0;
      dbWord    <= DB_RESET;
      phaseOff  <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        A_CTRL: begin
          stdSel   <= std_e'(wrData[1:0]);
          secamEn  <= wrData[2];
          customEn <= wrData[3];
        end
        A_FHI:   hiStage   <= wrData;
        A_FLO:   progWord  <= {hiStage, wrData};
        A_PHOFF: phaseOff  <= wrData[PH_W-1:0];
        A_DBHI:  dbHiStage <= wrData;
        A_DBLO:  dbWord    <= {dbHiStage, wrData};
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.clearAcc = softReset;
    strb.wordMain = (secamEn || customEn) ? progWord : builtinWord(stdSel);
    strb.wordAlt  = dbWord;
    strb.pickAlt  = secamEn & lineAlt;
    strb.offset   = phaseOff;
  end

  // R5: a low-half write commits the staged high half with the new low half
  p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr == A_FLO) |=> progWord == {$past(hiStage), $past(wrData)});

  // R5: a high-half write alone leaves the active word untouched
  p_hi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr == A_FHI) |=> $stable(progWord));

  // R6: the Db word commits the same way
  p_db_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr == A_DBLO) |=> dbWord == {$past(dbHiStage), $past(wrData)});

  // R9: unused addresses leave the words alone
  p_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr > A_DBLO) |=> ($stable(progWord) && $stable(dbWord) && $stable(phaseOff)));
endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
#(
  parameter int AW = ACC_W,
  parameter int PW = PH_W,
  parameter int NACC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  nco_strobe_t   strb,
  output logic [PW-1:0] phaseOut
);
  logic [AW-1:0] acc  [NACC];
  logic [AW-1:0] step [NACC];

  assign step[0] = strb.wordMain[AW-1:0];
  assign step[1] = strb.wordAlt[AW-1:0];

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             acc[g] <= '0;
      else if (strb.clearAcc) acc[g] <= '0;
      else                    acc[g] <= acc[g] + step[g];
    end
  end

  logic [AW-1:0] selAcc;
  assign selAcc   = strb.pickAlt ? acc[1] : acc[0];
  assign phaseOut = selAcc[AW-1 -: PW] + strb.offset;

  // R8: soft reset zeroes both accumulators
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearAcc |=> (acc[0] == '0 && acc[1] == '0));

  // R2: the main accumulator advances by its word modulo 2^AW
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clearAcc |=> acc[0] == AW'($past(acc[0]) + $past(step[0])));

  // R6: the Db accumulator advances by its own word
  p_step_alt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clearAcc |=> acc[1] == AW'($past(acc[1]) + $past(step[1])));
endmodule

// File: rtl/subcarrier_nco.sv
module subcarrier_nco
  import nco_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              softReset,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              lineAlt,
  output logic [PH_W-1:0]   phaseOut
);
  nco_strobe_t strb;

  nco_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .softReset(softReset), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .lineAlt(lineAlt), .strb(strb)
  );

  nco_datapath #(.AW(ACC_W), .PW(PH_W), .NACC(2)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .phaseOut(phaseOut)
  );
endmodule

// File: tb/test_subcarrier_nco.sv
`timescale 1ns/1ps
module test_subcarrier_nco;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        softReset = 0;
  logic        wrEn = 0;
  logic [2:0]  wrAddr = 0;
  logic [15:0] wrData = 0;
  logic        lineAlt = 0;
  logic [7:0]  phaseOut;

  always #5 clk = ~clk;

  subcarrier_nco i_subcarrier_nco (
    .clk(clk), .rst_n(rst_n), .softReset(softReset), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .lineAlt(lineAlt), .phaseOut(phaseOut)
  );

  int total = 0;
  int bad = 0;
  longint mA = 0, mB = 0;
  logic [31:0] wA = 0, wB = 32'h284BDA13;
  logic [7:0]  off = 0;
  bit secamOn = 0;
  localparam longint MASK = 64'h7FFF_FFFF;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic clearAcc();
    softReset = 1;
    @(negedge clk);
    softReset = 0;
    mA = 0; mB = 0;
  endtask

  // altMode: 0 low, 1 high, 2 toggling every 64 cycles
  task automatic runCheck(input int n, input string req, input int altMode);
    int nbad = 0;
    logic [7:0] fa = 0, fe = 0;
    for (int i = 0; i < n; i++) begin
      lineAlt = (altMode == 2) ? ((i / 64) % 2 == 1) : (altMode == 1);
      #1;
      begin
        longint src = (secamOn && lineAlt) ? mB : mA;
        logic [7:0] e = 8'((src >> 23) & 64'hFF) + off;
        if (phaseOut !== e) begin
          if (nbad == 0) begin fa = phaseOut; fe = e; end
          nbad++;
        end
      end
      mA = (mA + longint'(wA)) & MASK;
      mB = (mB + longint'(wB)) & MASK;
      @(negedge clk);
    end
    chk(nbad == 0, req, fa, fe);
  endtask

  initial begin
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(phaseOut == 8'h00, "R1 reset phase", phaseOut, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: NTSC built-in word runs from zero right after reset
    clearAcc();
    wA = 32'h21F07C1F;
    runCheck(64, "R1 reset defaults", 0);

    // R3/R2: each built-in word for 16384 cycles
    for (int s = 0; s < 4; s++) begin
      wr(3'd0, 16'(s));
      case (s)
        0: wA = 32'h21F07C1F;
        1: wA = 32'h2A098ACB;
        2: wA = 32'h21E6EFE3;
        default: wA = 32'h21F69446;
      endcase
      clearAcc();
      runCheck(16384, "R3 built-in word", 0);
    end

    // R7: phase offset 0x28 on PAL
    wr(3'd0, 16'd1); wr(3'd3, 16'h0028); off = 8'h28;
    wA = 32'h2A098ACB;
    clearAcc();
    #1; chk(phaseOut == 8'h28, "R7 offset at zero phase", phaseOut, 8'h28);
    runCheck(4096, "R7 offset added", 0);

    // R4/R5: custom with programmed word 0, then high half only
    wr(3'd0, 16'h0008); wA = 32'h0;
    clearAcc(); runCheck(256, "R4 custom zero word", 0);
    wr(3'd1, 16'h2A09);
    clearAcc(); runCheck(256, "R5 high half alone no effect", 0);
    wr(3'd2, 16'h8ACB); wA = 32'h2A098ACB;
    clearAcc(); runCheck(4096, "R5 low half commits word", 0);

    // R2: 0x80000000 equals the pixel rate, phase frozen
    wr(3'd1, 16'h8000); wr(3'd2, 16'h0000); wA = 32'h80000000;
    clearAcc(); runCheck(512, "R2 pixel-rate word", 0);

    // R4: custom off restores built-in NTSC word
    wr(3'd0, 16'h0000); wA = 32'h21F07C1F;
    clearAcc(); runCheck(2048, "R4 custom off", 0);

    // R6: SECAM Dr uses programmed word with custom off, Db default
    wr(3'd1, 16'h29C7); wr(3'd2, 16'h1C72); wr(3'd0, 16'h0004);
    secamOn = 1; wA = 32'h29C71C72;
    clearAcc(); runCheck(2048, "R6 SECAM Dr", 0);
    clearAcc(); runCheck(2048, "R6 SECAM Db default", 1);
    wr(3'd4, 16'h1234); wr(3'd5, 16'h5678); wB = 32'h12345678;
    clearAcc(); runCheck(4096, "R6 SECAM alternating Db programmed", 2);
    wr(3'd0, 16'h000C);
    clearAcc(); runCheck(1024, "R6 SECAM ignores custom bit", 2);

    // R8: soft reset mid-run keeps registers
    runCheck(700, "R8 before soft reset", 2);
    clearAcc();
    lineAlt = 0; #1;
    chk(phaseOut == off, "R8 phase cleared", phaseOut, off);
    runCheck(1000, "R8 registers kept", 2);

    // R9: unused addresses ignored
    wr(3'd6, 16'hFFFF); wr(3'd7, 16'h0000);
    clearAcc(); runCheck(1000, "R9 unused addresses", 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule